// File: doc/BRIEF.md
# Thermal Alarm Event Detector

This block watches an active-low alarm line from an external temperature sensor and turns a chosen transition of that line into a power-management interrupt. The alarm first crosses a two-stage synchronizer. An edge detector then compares the last two synchronized samples. A polarity control decides which direction of change counts as an event: alarm asserting, which means the threshold was exceeded, or alarm releasing, which means the temperature is back below it.

An event sets a sticky status flag. Software clears that flag by writing one to it. When the interrupt enable is set, the flag drives a level interrupt. A routing control steers that interrupt either to a system-management output or to an ACPI-style interrupt output. Software can arm the release polarity after handling an over-temperature interrupt, so that a second interrupt tells it when to switch cooling off.

A small register write port sets the controls and clears the status. The alarm line has no other effect on the block.

Top module: `thermal_alert_unit`

## Requirements
- R1: The alarm input passes two synchronizer flops before edge detection. A change driven on `alarm_n` shows in `evt_status` just after the third rising clock edge that follows the change, and not before.
- R2: With polarity 0, a high-to-low change of the synchronized alarm sets the status flag. A low-to-high change does not.
- R3: With polarity 1, a low-to-high change of the synchronized alarm sets the status flag. A high-to-low change does not.
- R4: The status flag stays set until a write to address 1 with bit 0 of the data equal to 1 clears it. A write to address 1 with bit 0 equal to 0 leaves it unchanged.
- R5: When an event and a status-clearing write fall on the same clock edge, the flag ends up set.
- R6: An interrupt output is high only while both the status flag and the enable control are 1. With the enable at 0, an event still sets the status flag but raises no interrupt.
- R7: With the routing control at 1, the interrupt appears on `sci_o`. With it at 0, the interrupt appears on `smi_o`. The two outputs are never high together.
- R8: After a synchronous active-low reset, the status flag, the enable and the polarity are 0, and the routing selects `smi_o`.
- R9: A write to address 0 loads the controls: bit 0 is the enable, bit 1 the polarity, and bit 2 the routing. The block ignores the other data bits. Control changes take effect on the edge of the write.
- R10: An alarm that stays at one level produces no further events. After a clear, the flag stays 0 until a new qualifying transition has passed the synchronizer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| alarm_n | input | 1 | Asynchronous thermal alarm, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Register select: 0 controls, 1 status clear |
| wr_data | input | DATA_W | Write data |
| evt_status | output | 1 | Sticky thermal event flag |
| smi_o | output | 1 | System-management interrupt level |
| sci_o | output | 1 | ACPI-style interrupt level |

## Verification
A change on the alarm is due on `evt_status` after exactly three rising edges. The bench checks the two edges before as well, to show the flag has not moved early. A write takes effect on its own edge. The interrupt outputs are combinational from the flag and the controls, so they move in the same cycle as the flag or the control write. The bench drives every input at the falling edge and steps a reference model once per rising edge. It compares all three outputs one time unit after each rising edge, so every check lands on the cycle in which its result is due.

// File: rtl/therm_pkg.sv
// Shared definitions for the thermal alarm event detector.
// Assumes the register select is a single bit and the data bus is at least 3 bits wide.
package therm_pkg;

    // Register select values on the write port
    typedef enum logic {
        SEL_CTRL  = 1'b0,
        SEL_CLEAR = 1'b1
    } therm_sel_e;

    // Bit positions of the control fields and of the status-clear bit
    localparam int unsigned CTL_EN_POS    = 0;
    localparam int unsigned CTL_POL_POS   = 1;
    localparam int unsigned CTL_ROUTE_POS = 2;
    localparam int unsigned CLR_POS       = 0;

    // Control state held by the register block
    typedef struct packed {
        logic route_acpi;
        logic pol_rise;
        logic irq_en;
    } therm_ctrl_t;

endpackage

// File: rtl/therm_sync.sv
// Synchronizes the asynchronous alarm line and keeps one extra delayed sample
// so that a later stage can detect a change between two consecutive samples.
// Assumes the alarm idles high (inactive), so every stage resets to 1.
module therm_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic alarm_n,
    output logic lvl_now,
    output logic lvl_prev
);
    localparam int unsigned LAST = STAGES - 1;

    logic [STAGES-1:0] chain;
    logic              prev_q;

    // Shift the alarm through the synchronizer and keep the previous synchronized value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain  <= '1;
            prev_q <= 1'b1;
        end else begin
            chain  <= {chain[STAGES-2:0], alarm_n};
            prev_q <= chain[LAST];
        end
    end

    assign lvl_now  = chain[LAST];
    assign lvl_prev = prev_q;

    // R1
    sync_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> lvl_prev == $past(lvl_now));
endmodule

// File: rtl/therm_regs.sv
// Holds the control fields and the sticky status flag. It selects the active
// edge of the synchronized alarm from the polarity field and handles
// write-one-to-clear, with a set winning over a clear on the same edge.
// Assumes lvl_now/lvl_prev come from a synchronizer and are glitch free.
module therm_regs
    import therm_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lvl_now,
    input  logic              lvl_prev,
    input  logic              wr_en,
    input  therm_sel_e        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output therm_ctrl_t       ctrl,
    output logic              status
);
    logic fell, rose, evt, clr, ctrl_we;
    therm_ctrl_t ctrl_q;
    logic status_q;

    // Pick the qualifying transition from the polarity field
    always_comb begin
        fell = lvl_prev & ~lvl_now;
        rose = ~lvl_prev & lvl_now;
        evt  = ctrl_q.pol_rise ? rose : fell;
    end

    // Decode the write port into a control load and a status clear
    always_comb begin
        ctrl_we = wr_en && (wr_sel == SEL_CTRL);
        clr     = wr_en && (wr_sel == SEL_CLEAR) && wr_data[CLR_POS];
    end

    // Load the control fields on a control write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (ctrl_we) begin
            ctrl_q.irq_en     <= wr_data[CTL_EN_POS];
            ctrl_q.pol_rise   <= wr_data[CTL_POL_POS];
            ctrl_q.route_acpi <= wr_data[CTL_ROUTE_POS];
        end
    end

    // Sticky status: an event sets it, write-one clears it, the set wins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= 1'b0;
        end else if (evt) begin
            status_q <= 1'b1;
        end else if (clr) begin
            status_q <= 1'b0;
        end
    end

    assign ctrl   = ctrl_q;
    assign status = status_q;

    // R2
    // R3
    // R5
    evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> status);

    // R4
    clear_works_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr && !evt |=> !status);

    // R4
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status && !clr |=> status);

    // R10
    no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !status && (lvl_now == lvl_prev) |=> !status);
endmodule

// File: rtl/therm_irq_route.sv
// Forms the interrupt level from the status flag and the enable, and steers it
// to one of two interrupt outputs. Purely combinational.
// Assumes the controls and the status come from registers.
module therm_irq_route
    import therm_pkg::*;
(
    input  therm_ctrl_t ctrl,
    input  logic        status,
    output logic        smi,
    output logic        sci
);
    logic irq_lvl;

    // Gate the status with the enable, then steer by the routing field
    always_comb begin
        irq_lvl = status & ctrl.irq_en;
        sci     = irq_lvl & ctrl.route_acpi;
        smi     = irq_lvl & ~ctrl.route_acpi;
    end
endmodule

// File: rtl/thermal_alert_unit.sv
// Top of the thermal alarm event detector: synchronizer, register block with
// edge selection, and interrupt routing.
// Assumes alarm_n is asynchronous and idles high, and the reset is synchronous.
module thermal_alert_unit
    import therm_pkg::*;
#(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alarm_n,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              evt_status,
    output logic              smi_o,
    output logic              sci_o
);
    logic        lvl_now, lvl_prev;
    therm_ctrl_t ctrl;
    therm_sel_e  sel;

    assign sel = therm_sel_e'(wr_addr);

    therm_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .alarm_n  (alarm_n),
        .lvl_now  (lvl_now),
        .lvl_prev (lvl_prev)
    );

    therm_regs #(.DATA_W(DATA_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .lvl_now  (lvl_now),
        .lvl_prev (lvl_prev),
        .wr_en    (wr_en),
        .wr_sel   (sel),
        .wr_data  (wr_data),
        .ctrl     (ctrl),
        .status   (evt_status)
    );

    therm_irq_route u_route (
        .ctrl   (ctrl),
        .status (evt_status),
        .smi    (smi_o),
        .sci    (sci_o)
    );

    // R7
    one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({smi_o, sci_o}));

    // R6
    irq_needs_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smi_o || sci_o) |-> evt_status);

    // R8
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> !evt_status && !smi_o && !sci_o);
endmodule

// File: tb/thermal_alert_unit_test.sv
// Self-checking bench: directed corner cases followed by seeded random
// stimulus, compared against a cycle model built from the requirements.
module thermal_alert_unit_test;
    localparam int  PERIOD = 10;
    localparam int  DW     = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          alarm_n = 1'b1;
    logic          wr_en = 1'b0;
    logic          wr_addr = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          evt_status, smi_o, sci_o;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // Model state: three sampled alarm values (R1), status, controls
    logic h0 = 1'b1, h1 = 1'b1, h2 = 1'b1;
    logic m_st = 1'b0, m_en = 1'b0, m_pol = 1'b0, m_rt = 1'b0;

    thermal_alert_unit #(.DATA_W(DW), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst_n(rst_n), .alarm_n(alarm_n), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .evt_status(evt_status),
        .smi_o(smi_o), .sci_o(sci_o)
    );

    always #(PERIOD/2) clk = ~clk;

    function automatic logic model_evt(logic pol, logic now, logic prev);
        return pol ? (now & ~prev) : (~now & prev);
    endfunction

    task automatic chk(input logic act, input logic exp, input string tag, input string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%b expected=%b at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare(input string tag);
        chk(evt_status, m_st, tag, "status");
        chk(smi_o, m_st & m_en & ~m_rt, "R7", "smi");
        chk(sci_o, m_st & m_en & m_rt, "R6", "sci");
    endtask

    // Drive one cycle, advance the model on the rising edge, compare after it
    task automatic step(input logic a, input logic we, input logic ad,
                        input logic [DW-1:0] d, input string tag);
        logic e, c;
        @(negedge clk);
        alarm_n = a; wr_en = we; wr_addr = ad; wr_data = d;
        @(posedge clk);
        e = model_evt(m_pol, h1, h2);
        c = we && ad && d[0];
        m_st = e | (m_st & ~c);
        if (we && !ad) begin
            m_en = d[0]; m_pol = d[1]; m_rt = d[2];
        end
        h2 = h1; h1 = h0; h0 = a;
        #1;
        compare(tag);
    endtask

    task automatic idle(input logic a, input int n, input string tag);
        for (int i = 0; i < n; i++) step(a, 1'b0, 1'b0, '0, tag);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        #(PERIOD * 150000);
        bad++;
        $display("FAIL watchdog: actual=running expected=done");
        finish_run();
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd20240);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8: reset state
        chk(evt_status, 1'b0, "R8", "status after reset");
        chk(smi_o, 1'b0, "R8", "smi after reset");
        chk(sci_o, 1'b0, "R8", "sci after reset");

        // R1: falling alarm due on the third edge; R2 polarity 0; R6 enable 0
        step(1'b0, 1'b0, 1'b0, '0, "R1");
        chk(evt_status, 1'b0, "R1", "early edge 1");
        step(1'b0, 1'b0, 1'b0, '0, "R1");
        chk(evt_status, 1'b0, "R1", "early edge 2");
        step(1'b0, 1'b0, 1'b0, '0, "R2");
        chk(evt_status, 1'b1, "R1", "due on edge 3");
        chk(smi_o, 1'b0, "R6", "no irq with enable 0");

        // R8/R9: enable only; routing still defaults to smi
        step(1'b0, 1'b1, 1'b0, 8'hF9 & 8'h01 | 8'hF0, "R9");
        chk(smi_o, 1'b1, "R8", "default route smi");

        // R4: write 0 to clear bit keeps status; write 1 clears
        step(1'b0, 1'b1, 1'b1, 8'hFE, "R4");
        chk(evt_status, 1'b1, "R4", "write zero keeps");
        step(1'b0, 1'b1, 1'b1, 8'h01, "R4");
        chk(evt_status, 1'b0, "R4", "write one clears");

        // R10: held low level gives no new event
        idle(1'b0, 5, "R10");
        chk(evt_status, 1'b0, "R10", "held level");

        // R2: rising with polarity 0 ignored
        idle(1'b1, 5, "R2");
        chk(evt_status, 1'b0, "R2", "rise ignored at pol 0");

        // R3: polarity 1, falling ignored, rising sets
        step(1'b1, 1'b1, 1'b0, 8'h03, "R9");
        idle(1'b0, 5, "R3");
        chk(evt_status, 1'b0, "R3", "fall ignored at pol 1");
        idle(1'b1, 3, "R3");
        chk(evt_status, 1'b1, "R3", "rise sets at pol 1");
        chk(smi_o, 1'b1, "R7", "smi route");

        // R7: route to ACPI output
        step(1'b1, 1'b1, 1'b0, 8'h07, "R7");
        chk(sci_o, 1'b1, "R7", "sci route");
        chk(smi_o, 1'b0, "R7", "smi quiet");

        // R5: clear on the same edge as an event
        step(1'b1, 1'b1, 1'b1, 8'h01, "R4");
        idle(1'b0, 4, "R3");
        step(1'b1, 1'b0, 1'b0, '0, "R5");
        step(1'b1, 1'b0, 1'b0, '0, "R5");
        step(1'b1, 1'b1, 1'b1, 8'h01, "R5");
        chk(evt_status, 1'b1, "R5", "set wins over clear");

        // Random phase against the model
        for (int i = 0; i < 3000; i++) begin
            logic a, we, ad;
            logic [DW-1:0] d;
            a  = ($urandom % 4 == 0) ? ~alarm_n : alarm_n;
            we = ($urandom % 5 == 0);
            ad = $urandom % 2;
            d  = DW'($urandom);
            step(a, we, ad, d, "R9");
        end
        finish_run();
    end
endmodule